// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small, fully associative cache of page translations. Each slot holds a virtual page number, the frame it maps to, the address-space tag under which it was filled, a global flag and a valid bit. A lookup presents a page number and is compared in the same cycle against every slot. A slot answers if its page number matches and it is either marked global or carries the tag held in the block's current address-space register. The frame number comes back combinationally.

Software-side events reach the block as single-cycle command strobes. A fill installs a translation. An address-space switch loads a new tag and either keeps every slot or drops the untagged-safe ones. A page invalidate drops one page, and a full flush empties the table. Replacement is first-in-first-out by insertion order. A wrapping counter of missed lookups lets a caller compare a schedule run with kept entries against the same schedule run with dropped entries.

Top module: `xlat_cache`

## Requirements
- R1: A lookup hits in the same cycle when some valid slot has the presented page number and is either global or tagged with the current address-space value. On a hit `lk_pfn` is that slot's frame. On a miss `lk_hit` is 0 and `lk_pfn` is all zeros.
- R2: The address-space register is 12 bits wide and resets to 0. An accepted switch loads `sw_asid` into it, visible on `cur_asid` from the next cycle. No other command changes it.
- R3: A switch with `sw_keep` = 1 leaves every slot valid, so translations of the previous address space hit again after switching back.
- R4: A switch with `sw_keep` = 0 invalidates every non-global slot and leaves global slots valid.
- R5: A global slot hits for any current address-space value.
- R6: A page invalidate removes every slot for `inv_vpn` that is global or tagged with the current address space. It takes effect on the next cycle. Slots of other pages, and slots for that page under other tags, stay valid.
- R7: A full flush invalidates every slot, global ones included.
- R8: A fill that matches no slot takes the lowest-numbered free slot. When all 4 slots are valid, it replaces the slot inserted longest ago. An in-place refill does not renew a slot's insertion age.
- R9: A fill whose page already hits under the R1 rule overwrites that slot's frame and global flag in place. It allocates no second slot.
- R10: `miss_count` (16 bits, reset 0, wrapping) adds one on every cycle with `lk_valid` = 1 and a miss. It is unchanged by hits and by cycles with `lk_valid` = 0.
- R11: At most one command runs per cycle, chosen in the order flush, then switch, then page invalidate, then fill. Lower-ranked commands asserted in the same cycle are dropped.
- R12: After reset all slots are invalid, `cur_asid` is 0 and `miss_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup is real and counts toward misses |
| lk_vpn | input | 20 | Page number to translate |
| lk_hit | output | 1 | Lookup hit |
| lk_pfn | output | 20 | Translated frame, zero on miss |
| fill_en | input | 1 | Install a translation |
| fill_vpn | input | 20 | Page number to install |
| fill_pfn | input | 20 | Frame to install |
| fill_global | input | 1 | Installed slot matches every address space |
| sw_en | input | 1 | Load a new address-space value |
| sw_asid | input | 12 | New address-space value |
| sw_keep | input | 1 | Keep all slots across the switch |
| inv_en | input | 1 | Invalidate one page |
| inv_vpn | input | 20 | Page to invalidate |
| flush_en | input | 1 | Invalidate all slots |
| cur_asid | output | 12 | Current address-space value |
| miss_count | output | 16 | Count of counted lookup misses |

## Verification
The bench replays a two-process schedule twice, once with kept switches (4 misses) and once with dropping switches (6 misses). A design that ignores the tag, or drops slots on a kept switch, shows the wrong count. The FIFO test refills a slot in place, invalidates a middle slot and fills again. A design that renews age on refill, evicts instead of filling a hole, or miscounts ranks after a removal loses the wrong page. Other tests check that global slots survive a dropping switch but not a flush, that a page invalidate spares the same page under another tag, and that a dropped lower-priority command leaves no trace.

// File: rtl/xlat_pkg.sv
// Package: shared command encoding for the tagged translation cache.
// Assumes at most one command is executed per cycle.
package xlat_pkg;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_FLUSH  = 3'd1,
        OP_SWITCH = 3'd2,
        OP_INV    = 3'd3,
        OP_FILL   = 3'd4
    } xlat_op_e;

    // Picks the single command to run: flush, switch, invalidate, fill.
    function automatic xlat_op_e pick_op(input logic flush, input logic sw,
                                         input logic inv, input logic fill);
        if (flush)     return OP_FLUSH;
        else if (sw)   return OP_SWITCH;
        else if (inv)  return OP_INV;
        else if (fill) return OP_FILL;
        else           return OP_NONE;
    endfunction

endpackage

// File: rtl/xlat_match.sv
// Module: xlat_match
// Compares one key page number against every slot and reports which slots
// answer under the current address space (global slots always answer).
// Assumes DEPTH >= 2. Purely combinational.
module xlat_match #(
    parameter int DEPTH  = 4,
    parameter int VPN_W  = 20,
    parameter int ASID_W = 12,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]             ent_valid,
    input  logic [DEPTH-1:0]             ent_glob,
    input  logic [DEPTH-1:0][VPN_W-1:0]  ent_vpn,
    input  logic [DEPTH-1:0][ASID_W-1:0] ent_asid,
    input  logic [ASID_W-1:0]            cur_asid,
    input  logic [VPN_W-1:0]             key_vpn,
    output logic [DEPTH-1:0]             hit_vec,
    output logic                         any_hit,
    output logic [IDX_W-1:0]             first_idx
);

    // One comparator per slot.
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign hit_vec[i] = ent_valid[i] && (ent_vpn[i] == key_vpn) &&
                            (ent_glob[i] || (ent_asid[i] == cur_asid));
    end

    assign any_hit = |hit_vec;

    // Lowest-numbered answering slot wins.
    always_comb begin
        first_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (hit_vec[i]) first_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/xlat_age.sv
// Module: xlat_age
// Keeps an insertion rank per slot (0 = newest) so the FIFO victim is the
// slot of rank DEPTH-1 when the table is full. Removals close the gaps in
// the ranks; an insertion ages every other valid slot by one.
// Assumes removal and insertion never occur in the same cycle.
module xlat_age #(
    parameter int DEPTH = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] valid,
    input  logic [DEPTH-1:0] rm,
    input  logic             ins_en,
    input  logic [IDX_W-1:0] ins_idx,
    output logic [IDX_W-1:0] victim_idx
);

    logic [DEPTH-1:0][IDX_W-1:0] rank_q;
    logic [DEPTH-1:0][IDX_W-1:0] dec;
    logic                        free_found;

    // Counts, per slot, the removed slots that are newer than it.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            dec[i] = '0;
            for (int j = 0; j < DEPTH; j++) begin
                if (rm[j] && valid[j] && (rank_q[j] < rank_q[i]))
                    dec[i] = dec[i] + IDX_W'(1);
            end
        end
    end

    // Chooses the lowest free slot, else the oldest inserted one.
    always_comb begin
        victim_idx = '0;
        free_found = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!valid[i] && !free_found) begin
                victim_idx = IDX_W'(i);
                free_found = 1'b1;
            end
        end
        if (!free_found) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (rank_q[i] == IDX_W'(DEPTH - 1)) victim_idx = IDX_W'(i);
            end
        end
    end

    // Updates the ranks on insertion or removal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rank_q <= '0;
        end else if (ins_en) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (IDX_W'(i) == ins_idx)
                    rank_q[i] <= '0;
                else if (valid[i])
                    rank_q[i] <= rank_q[i] + IDX_W'(1);
            end
        end else if (|rm) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (valid[i] && !rm[i]) rank_q[i] <= rank_q[i] - dec[i];
            end
        end
    end

endmodule

// File: rtl/xlat_miss_ctr.sv
// Module: xlat_miss_ctr
// Wrapping counter of counted lookup misses. Assumes inc is a one-cycle event.
module xlat_miss_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    // Adds one per counted miss, wrapping at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (inc) count <= count + CNT_W'(1);
    end

endmodule

// File: rtl/xlat_cache.sv
// Module: xlat_cache
// Fully associative translation cache with address-space tags and global
// slots. Lookup is combinational against the current tag register; fill,
// switch, page invalidate and flush are single-cycle commands, one per cycle.
// Assumes callers never rely on two slots answering the same page.
module xlat_cache #(
    parameter int DEPTH  = 4,
    parameter int VPN_W  = 20,
    parameter int PFN_W  = 20,
    parameter int ASID_W = 12,
    parameter int CNT_W  = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    output logic              lk_hit,
    output logic [PFN_W-1:0]  lk_pfn,
    input  logic              fill_en,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic              fill_global,
    input  logic              sw_en,
    input  logic [ASID_W-1:0] sw_asid,
    input  logic              sw_keep,
    input  logic              inv_en,
    input  logic [VPN_W-1:0]  inv_vpn,
    input  logic              flush_en,
    output logic [ASID_W-1:0] cur_asid,
    output logic [CNT_W-1:0]  miss_count
);
    import xlat_pkg::*;

    logic [DEPTH-1:0]             v_q;
    logic [DEPTH-1:0]             g_q;
    logic [DEPTH-1:0][VPN_W-1:0]  vpn_q;
    logic [DEPTH-1:0][PFN_W-1:0]  pfn_q;
    logic [DEPTH-1:0][ASID_W-1:0] asid_q;
    logic [ASID_W-1:0]            cur_q;

    xlat_op_e         op;
    logic [DEPTH-1:0] lk_vec, inv_vec, fill_vec, rm;
    logic             lk_any, inv_any, fill_any;
    logic [IDX_W-1:0] lk_idx, inv_idx, fill_idx, vic_idx, wr_idx;
    logic             ins_new;

    assign op = pick_op(flush_en, sw_en, inv_en, fill_en);

    xlat_match #(.DEPTH(DEPTH), .VPN_W(VPN_W), .ASID_W(ASID_W)) i_lk_match (
        .ent_valid(v_q), .ent_glob(g_q), .ent_vpn(vpn_q), .ent_asid(asid_q),
        .cur_asid(cur_q), .key_vpn(lk_vpn),
        .hit_vec(lk_vec), .any_hit(lk_any), .first_idx(lk_idx)
    );

    xlat_match #(.DEPTH(DEPTH), .VPN_W(VPN_W), .ASID_W(ASID_W)) i_inv_match (
        .ent_valid(v_q), .ent_glob(g_q), .ent_vpn(vpn_q), .ent_asid(asid_q),
        .cur_asid(cur_q), .key_vpn(inv_vpn),
        .hit_vec(inv_vec), .any_hit(inv_any), .first_idx(inv_idx)
    );

    xlat_match #(.DEPTH(DEPTH), .VPN_W(VPN_W), .ASID_W(ASID_W)) i_fill_match (
        .ent_valid(v_q), .ent_glob(g_q), .ent_vpn(vpn_q), .ent_asid(asid_q),
        .cur_asid(cur_q), .key_vpn(fill_vpn),
        .hit_vec(fill_vec), .any_hit(fill_any), .first_idx(fill_idx)
    );

    // Drives the lookup result; frame forced to zero on a miss.
    always_comb begin
        lk_hit = lk_any;
        lk_pfn = lk_any ? pfn_q[lk_idx] : '0;
    end

    // Builds the removal mask of the command being executed.
    always_comb begin
        unique case (op)
            OP_FLUSH:  rm = v_q;
            OP_SWITCH: rm = sw_keep ? '0 : (v_q & ~g_q);
            OP_INV:    rm = inv_any ? inv_vec : '0;
            default:   rm = '0;
        endcase
    end

    // Selects the slot written by a fill: in place, else the FIFO victim.
    always_comb begin
        ins_new = (op == OP_FILL) && !fill_any;
        wr_idx  = fill_any ? fill_idx : vic_idx;
    end

    xlat_age #(.DEPTH(DEPTH)) i_age (
        .clk(clk), .rst_n(rst_n), .valid(v_q), .rm(rm),
        .ins_en(ins_new), .ins_idx(vic_idx), .victim_idx(vic_idx)
    );

    // Holds slot contents and the current address-space register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q    <= '0;
            g_q    <= '0;
            vpn_q  <= '0;
            pfn_q  <= '0;
            asid_q <= '0;
            cur_q  <= '0;
        end else begin
            v_q <= v_q & ~rm;
            if (op == OP_SWITCH) cur_q <= sw_asid;
            if (op == OP_FILL) begin
                v_q[wr_idx]    <= 1'b1;
                g_q[wr_idx]    <= fill_global;
                vpn_q[wr_idx]  <= fill_vpn;
                pfn_q[wr_idx]  <= fill_pfn;
                asid_q[wr_idx] <= cur_q;
            end
        end
    end

    assign cur_asid = cur_q;

    xlat_miss_ctr #(.CNT_W(CNT_W)) i_miss (
        .clk(clk), .rst_n(rst_n), .inc(lk_valid && !lk_any), .count(miss_count)
    );

endmodule

// File: rtl/xlat_cache_chk.sv
// Module: xlat_cache_chk
// Port-level temporal checks for xlat_cache, attached with bind below.
module xlat_cache_chk #(
    parameter int VPN_W  = 20,
    parameter int PFN_W  = 20,
    parameter int ASID_W = 12,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic [VPN_W-1:0]  lk_vpn,
    input logic              lk_hit,
    input logic [PFN_W-1:0]  lk_pfn,
    input logic              fill_en,
    input logic [VPN_W-1:0]  fill_vpn,
    input logic [PFN_W-1:0]  fill_pfn,
    input logic              sw_en,
    input logic [ASID_W-1:0] sw_asid,
    input logic              inv_en,
    input logic [VPN_W-1:0]  inv_vpn,
    input logic              flush_en,
    input logic [ASID_W-1:0] cur_asid,
    input logic [CNT_W-1:0]  miss_count
);

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        flush_en |=> !lk_hit); // R7

    AST_ASID_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en && !flush_en) |=> (cur_asid == $past(sw_asid))); // R2

    AST_ASID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_en || flush_en) |=> $stable(cur_asid)); // R2

    AST_INV_PAGE_GONE: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_en && !flush_en && !sw_en) |=>
        ((lk_vpn != $past(inv_vpn)) || !lk_hit)); // R6

    AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flush_en && !sw_en && !inv_en) |=>
        ((lk_vpn != $past(fill_vpn)) || (lk_hit && lk_pfn == $past(fill_pfn)))); // R9

    AST_MISS_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_hit) |=> (miss_count == $past(miss_count) + CNT_W'(1))); // R10

    AST_HIT_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!lk_valid || lk_hit) |=> $stable(miss_count)); // R10

endmodule

bind xlat_cache xlat_cache_chk #(
    .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W), .CNT_W(CNT_W)
) i_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
    .lk_hit(lk_hit), .lk_pfn(lk_pfn), .fill_en(fill_en), .fill_vpn(fill_vpn),
    .fill_pfn(fill_pfn), .sw_en(sw_en), .sw_asid(sw_asid), .inv_en(inv_en),
    .inv_vpn(inv_vpn), .flush_en(flush_en), .cur_asid(cur_asid),
    .miss_count(miss_count)
);

// File: tb/test_xlat_cache.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module test_xlat_cache;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic        lk_hit;
    logic [19:0] lk_pfn;
    logic        fill_en = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_pfn = '0;
    logic        fill_global = 1'b0;
    logic        sw_en = 1'b0;
    logic [11:0] sw_asid = '0;
    logic        sw_keep = 1'b0;
    logic        inv_en = 1'b0;
    logic [19:0] inv_vpn = '0;
    logic        flush_en = 1'b0;
    logic [11:0] cur_asid;
    logic [15:0] miss_count;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    xlat_cache i_xlat_cache (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
        .lk_hit(lk_hit), .lk_pfn(lk_pfn), .fill_en(fill_en), .fill_vpn(fill_vpn),
        .fill_pfn(fill_pfn), .fill_global(fill_global), .sw_en(sw_en),
        .sw_asid(sw_asid), .sw_keep(sw_keep), .inv_en(inv_en), .inv_vpn(inv_vpn),
        .flush_en(flush_en), .cur_asid(cur_asid), .miss_count(miss_count)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Every op starts and ends at a falling edge.
    task automatic do_fill(input logic [19:0] v, input logic [19:0] p, input logic g);
        fill_en = 1'b1; fill_vpn = v; fill_pfn = p; fill_global = g;
        @(negedge clk);
        fill_en = 1'b0; fill_global = 1'b0;
    endtask

    task automatic do_switch(input logic [11:0] a, input logic keep);
        sw_en = 1'b1; sw_asid = a; sw_keep = keep;
        @(negedge clk);
        sw_en = 1'b0;
    endtask

    task automatic do_inv(input logic [19:0] v);
        inv_en = 1'b1; inv_vpn = v;
        @(negedge clk);
        inv_en = 1'b0;
    endtask

    task automatic do_flush();
        flush_en = 1'b1;
        @(negedge clk);
        flush_en = 1'b0;
    endtask

    task automatic probe(input logic [19:0] v, input logic cnt,
                         output logic hit, output logic [19:0] pfn);
        lk_vpn = v; lk_valid = cnt;
        #1;
        hit = lk_hit; pfn = lk_pfn;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic look(input logic [19:0] v, input logic eh, input logic [19:0] ep,
                        input string req);
        logic h;
        logic [19:0] p;
        probe(v, 1'b1, h, p);
        check(h == eh, req, $sformatf("hit vpn %0h", v), 32'(h), 32'(eh));
        check(p == (eh ? ep : 20'h0), req, $sformatf("pfn vpn %0h", v), 32'(p),
              32'(eh ? ep : 20'h0));
    endtask

    task automatic t_reset();
        check(cur_asid == 12'h0, "R12", "cur_asid", 32'(cur_asid), 0);
        check(miss_count == 16'h0, "R12", "miss_count", 32'(miss_count), 0);
        look(20'h10, 1'b0, 20'h0, "R12");
        check(miss_count == 16'd1, "R10", "count after miss", 32'(miss_count), 1);
    endtask

    // Two-process schedule; misses are filled with frame vpn+0x100.
    task automatic t_schedule(input logic keep, input int exp_miss, input string req);
        int as[7] = '{1, 1, 1, 2, 2, 1, 1};
        int vp[7] = '{10, 11, 10, 10, 20, 10, 11};
        int last = -1;
        logic [15:0] base;
        logic h;
        logic [19:0] p;
        do_flush();
        base = miss_count;
        for (int i = 0; i < 7; i++) begin
            if (as[i] != last) begin
                do_switch(12'(as[i]), keep);
                last = as[i];
            end
            probe(20'(vp[i]), 1'b1, h, p);
            if (!h) do_fill(20'(vp[i]), 20'(vp[i] + 'h100), 1'b0);
            else check(p == 20'(vp[i] + 'h100), req, "schedule pfn", 32'(p),
                       32'(vp[i] + 'h100));
        end
        check(miss_count - base == 16'(exp_miss), req, "schedule misses",
              32'(miss_count - base), 32'(exp_miss));
    endtask

    task automatic t_global();
        do_flush();
        do_switch(12'h3, 1'b1);
        do_fill(20'h50, 20'hA50, 1'b1);
        do_fill(20'h51, 20'hA51, 1'b0);
        do_switch(12'h9, 1'b0);
        look(20'h50, 1'b1, 20'hA50, "R5");
        look(20'h51, 1'b0, 20'h0, "R4");
        do_switch(12'h3, 1'b1);
        look(20'h51, 1'b0, 20'h0, "R4");
        look(20'h50, 1'b1, 20'hA50, "R4");
    endtask

    task automatic t_inv();
        do_flush();
        do_switch(12'h4, 1'b1);
        do_fill(20'h60, 20'hB60, 1'b0);
        do_fill(20'h61, 20'hB61, 1'b0);
        do_switch(12'h5, 1'b1);
        do_fill(20'h60, 20'hC60, 1'b0);
        do_inv(20'h60);
        look(20'h60, 1'b0, 20'h0, "R6");
        do_switch(12'h4, 1'b1);
        look(20'h60, 1'b1, 20'hB60, "R6");
        look(20'h61, 1'b1, 20'hB61, "R3");
        do_inv(20'h61);
        look(20'h61, 1'b0, 20'h0, "R6");
        look(20'h60, 1'b1, 20'hB60, "R6");
        do_fill(20'h70, 20'hB70, 1'b1);
        do_switch(12'h6, 1'b1);
        do_inv(20'h70);
        do_switch(12'h4, 1'b1);
        look(20'h70, 1'b0, 20'h0, "R6");
    endtask

    task automatic t_flush();
        do_flush();
        do_fill(20'h80, 20'hD80, 1'b1);
        do_fill(20'h81, 20'hD81, 1'b0);
        look(20'h80, 1'b1, 20'hD80, "R7");
        do_flush();
        look(20'h80, 1'b0, 20'h0, "R7");
        look(20'h81, 1'b0, 20'h0, "R7");
    endtask

    task automatic t_fifo();
        do_flush();
        do_switch(12'h1, 1'b1);
        do_fill(20'hA, 20'h1A, 1'b0);
        do_fill(20'hB, 20'h1B, 1'b0);
        do_fill(20'hC, 20'h1C, 1'b0);
        do_fill(20'hD, 20'h1D, 1'b0);
        do_fill(20'hB, 20'h2B, 1'b0);
        look(20'hB, 1'b1, 20'h2B, "R9");
        look(20'hA, 1'b1, 20'h1A, "R9");
        do_fill(20'hE, 20'h1E, 1'b0);
        look(20'hA, 1'b0, 20'h0, "R8");
        look(20'hB, 1'b1, 20'h2B, "R8");
        look(20'hE, 1'b1, 20'h1E, "R8");
        do_fill(20'hF, 20'h1F, 1'b0);
        look(20'hB, 1'b0, 20'h0, "R8");
        look(20'hC, 1'b1, 20'h1C, "R8");
        do_inv(20'hC);
        do_fill(20'h9, 20'h19, 1'b0);
        look(20'hD, 1'b1, 20'h1D, "R8");
        look(20'h9, 1'b1, 20'h19, "R8");
        do_fill(20'h8, 20'h18, 1'b0);
        look(20'hD, 1'b0, 20'h0, "R8");
        look(20'hE, 1'b1, 20'h1E, "R8");
        look(20'hF, 1'b1, 20'h1F, "R8");
    endtask

    task automatic t_priority();
        do_flush();
        do_switch(12'h2, 1'b1);
        flush_en = 1'b1; fill_en = 1'b1; fill_vpn = 20'h90; fill_pfn = 20'hE90;
        @(negedge clk);
        flush_en = 1'b0; fill_en = 1'b0;
        look(20'h90, 1'b0, 20'h0, "R11");
        sw_en = 1'b1; sw_asid = 12'h7; sw_keep = 1'b1; fill_en = 1'b1;
        @(negedge clk);
        sw_en = 1'b0; fill_en = 1'b0;
        check(cur_asid == 12'h7, "R11", "switch over fill", 32'(cur_asid), 32'h7);
        look(20'h90, 1'b0, 20'h0, "R11");
        do_fill(20'h91, 20'hE91, 1'b0);
        inv_en = 1'b1; inv_vpn = 20'h91; fill_en = 1'b1; fill_vpn = 20'h91;
        fill_pfn = 20'hF91;
        @(negedge clk);
        inv_en = 1'b0; fill_en = 1'b0;
        look(20'h91, 1'b0, 20'h0, "R11");
        flush_en = 1'b1; sw_en = 1'b1; sw_asid = 12'h55;
        @(negedge clk);
        flush_en = 1'b0; sw_en = 1'b0;
        check(cur_asid == 12'h7, "R11", "flush over switch", 32'(cur_asid), 32'h7);
    endtask

    task automatic t_asid();
        do_flush();
        do_switch(12'hFFF, 1'b1);
        check(cur_asid == 12'hFFF, "R2", "cur_asid", 32'(cur_asid), 32'hFFF);
        do_fill(20'hA0, 20'hCA0, 1'b0);
        do_switch(12'h0, 1'b1);
        look(20'hA0, 1'b0, 20'h0, "R1");
        do_switch(12'hFFF, 1'b1);
        look(20'hA0, 1'b1, 20'hCA0, "R1");
    endtask

    task automatic t_counter();
        logic [15:0] base;
        logic h;
        logic [19:0] p;
        do_flush();
        do_fill(20'hB0, 20'hCB0, 1'b0);
        base = miss_count;
        probe(20'hB1, 1'b0, h, p);
        check(miss_count == base, "R10", "uncounted miss", 32'(miss_count), 32'(base));
        probe(20'hB0, 1'b1, h, p);
        check(miss_count == base, "R10", "hit no count", 32'(miss_count), 32'(base));
        probe(20'hB1, 1'b1, h, p);
        probe(20'hB2, 1'b1, h, p);
        check(miss_count == base + 16'd2, "R10", "two misses", 32'(miss_count),
              32'(base + 16'd2));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_schedule(1'b1, 4, "R3");
        t_schedule(1'b0, 6, "R4");
        t_global();
        t_inv();
        t_flush();
        t_fifo();
        t_priority();
        t_asid();
        t_counter();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #500000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule